// File: doc/BRIEF.md
# Eight-Port Omega Switching Network

This block connects eight requester ports (processors) to eight responder ports (memory modules) through three ranks of two-by-two switching elements. Between ranks, and in front of the first rank, the links are shuffled: the lower half and the upper half of the link set are interleaved one by one, which is a rotate-left of the link index. Every request carries a module number, an address, an operation code and a data word. Each rank steers a request on one bit of the module number, starting from the most significant bit. It then overwrites that bit with the number of the switch input the request came in on. A request therefore reaches its memory port holding the number of the processor that sent it.

Replies travel on a second, mirror-image network. A memory port returns a reply that keeps the recorded path in its module field. The reverse ranks consume those bits from the least significant end and steer the reply back to its sender. On the way they write back the output-line bits, so the reply leaves carrying the number of the memory that answered. Every switch input holds one message. Two messages that want the same switch output in the same cycle are served in round-robin turn. The loser waits in place and its input stops accepting. All ports use a valid/ready handshake.

Top module: `omega_net`

## Requirements
- R1: After a synchronous active-low reset, no request or reply output is valid and every request and reply input reports ready.
- R2: A message is a packed vector {module[3], address[16], opcode[1], value[32]} with the module field in the top bits; opcode 0 is READ and 1 is WRITE. A request whose module field is d leaves on memory port d. Rank k steers on module bit 2-k, where 0 selects the upper output and 1 the lower output.
- R3: Each rank replaces the module bit it used with the input line the request entered on (0 upper, 1 lower), so the module field at the memory port equals the sending processor's index.
- R4: Address, opcode and value pass through both networks unchanged.
- R5: A reply offered at memory port p with module field m leaves on processor port m with module field p.
- R6: With no contention and all readies high, a message accepted at an input appears at its output exactly three cycles later, in either direction.
- R7: Two requests whose paths share no switch, link or port are both delivered three cycles after entry.
- R8: When two messages need the same switch output in the same cycle, one is forwarded and the other follows one cycle later; no message is lost.
- R9: While an output is valid and not ready, it stays valid with unchanged contents. Once the single-entry registers on a path are full, the feeding input drops ready.
- R10: After a switch output serves a contested cycle, the next contested cycle on that output is granted to the other input.
- R11: Requests, and their replies, between a fixed processor and memory pair arrive in the order they were issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req_valid | input | 8 | Request offered per processor port |
| cpu_req_msg | input | 8x52 | Request message per processor port |
| cpu_req_ready | output | 8 | Network accepts the request |
| mem_req_valid | output | 8 | Request presented per memory port |
| mem_req_msg | output | 8x52 | Request message with recorded path |
| mem_req_ready | input | 8 | Memory takes the request |
| mem_rsp_valid | input | 8 | Reply offered per memory port |
| mem_rsp_msg | input | 8x52 | Reply message carrying the recorded path |
| mem_rsp_ready | output | 8 | Reverse network accepts the reply |
| cpu_rsp_valid | output | 8 | Reply presented per processor port |
| cpu_rsp_msg | output | 8x52 | Reply message, module field restored |
| cpu_rsp_ready | input | 8 | Processor takes the reply |

## Verification
Routing is first tried with two disjoint paths injected together. This separates correct steering and path recording from interference, and it pins the three-cycle latency in both directions. Two processors that share a first-rank switch then target one memory twice in a row. This tells a working arbiter from one that drops, duplicates or always favours one side. A stalled memory port fed by a stream shows whether the holding registers keep their contents and push back to the sender. Long runs of random destinations, opcodes and readies then check delivery, path bits, field integrity and per-pair ordering against a bench model of the memories.

// File: rtl/omega_pkg.sv
// Package omega_pkg
// Shared definitions for the omega network: the opcode encoding and the
// index permutations used to wire one rank of switches to the next.
// Assumes the link count is a power of two, written as an index width w.
package omega_pkg;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } omega_op_e;

    // Perfect shuffle: rotate a w-bit link index one place to the left.
    function automatic int shuffle_idx(input int v, input int w);
        return ((v << 1) | (v >> (w - 1))) & ((1 << w) - 1);
    endfunction

    // Inverse shuffle: rotate a w-bit link index one place to the right.
    function automatic int unshuffle_idx(input int v, input int w);
        return ((v >> 1) | ((v & 1) << (w - 1))) & ((1 << w) - 1);
    endfunction

endpackage

// File: rtl/omega_switch.sv
// Module omega_switch
// One 2x2 switching element. Each input owns a one-entry holding register.
// A held message asks for the output named by bit SEL_BIT of its data. When
// it leaves, that bit is overwritten with the index of the input it was held
// in. Each output arbitrates round-robin between the two inputs. A grant that
// is stalled by the downstream ready is locked, so the output contents stay
// stable until taken.
// Assumes: downstream ready may depend combinationally on its own state only.
module omega_switch #(
    parameter int MSG_W   = 52,
    parameter int SEL_BIT = 51
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i0_valid,
    input  logic [MSG_W-1:0] i0_data,
    output logic             i0_ready,
    input  logic             i1_valid,
    input  logic [MSG_W-1:0] i1_data,
    output logic             i1_ready,
    output logic             o0_valid,
    output logic [MSG_W-1:0] o0_data,
    input  logic             o0_ready,
    output logic             o1_valid,
    output logic [MSG_W-1:0] o1_data,
    input  logic             o1_ready
);

    logic             hv   [2];
    logic [MSG_W-1:0] hd   [2];
    logic             in_v [2];
    logic [MSG_W-1:0] in_d [2];
    logic             in_r [2];
    logic             req  [2][2];   // [output][input]
    logic             prio [2];
    logic             lock [2];
    logic             held [2];
    logic             sel  [2];
    logic             ov   [2];
    logic             ordy [2];
    logic             fire [2];
    logic [MSG_W-1:0] od   [2];
    logic             pop  [2];

    assign in_v[0] = i0_valid;
    assign in_v[1] = i1_valid;
    assign in_d[0] = i0_data;
    assign in_d[1] = i1_data;
    assign i0_ready = in_r[0];
    assign i1_ready = in_r[1];
    assign ordy[0] = o0_ready;
    assign ordy[1] = o1_ready;
    assign o0_valid = ov[0];
    assign o1_valid = ov[1];
    assign o0_data = od[0];
    assign o1_data = od[1];

    // Which held message wants which output.
    always_comb begin
        for (int o = 0; o < 2; o++) begin
            for (int i = 0; i < 2; i++) begin
                req[o][i] = hv[i] && (hd[i][SEL_BIT] == 1'(o));
            end
        end
    end

    // Per-output grant, rewritten output data and transfer strobe.
    always_comb begin
        for (int o = 0; o < 2; o++) begin
            ov[o] = req[o][0] || req[o][1];
            if (lock[o]) begin
                sel[o] = held[o];
            end else if (req[o][0] && req[o][1]) begin
                sel[o] = prio[o];
            end else begin
                sel[o] = req[o][1];
            end
            od[o]          = hd[sel[o]];
            od[o][SEL_BIT] = sel[o];
            fire[o]        = ov[o] && ordy[o];
        end
    end

    // Release of holding registers and input readiness.
    always_comb begin
        for (int i = 0; i < 2; i++) begin
            pop[i]  = (fire[0] && (sel[0] == 1'(i))) || (fire[1] && (sel[1] == 1'(i)));
            in_r[i] = !hv[i] || pop[i];
        end
    end

    // Holding registers: load on accept, clear when forwarded.
    always_ff @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                hv[i] <= 1'b0;
                hd[i] <= '0;
            end else if (in_v[i] && in_r[i]) begin
                hv[i] <= 1'b1;
                hd[i] <= in_d[i];
            end else if (pop[i]) begin
                hv[i] <= 1'b0;
            end
        end
    end

    // Arbiter state: round-robin pointer and stall lock per output.
    always_ff @(posedge clk) begin
        for (int o = 0; o < 2; o++) begin
            if (!rst_n) begin
                prio[o] <= 1'b0;
                lock[o] <= 1'b0;
                held[o] <= 1'b0;
            end else begin
                if (fire[o] && req[o][0] && req[o][1]) begin
                    prio[o] <= !sel[o];
                end
                lock[o] <= ov[o] && !ordy[o];
                held[o] <= sel[o];
            end
        end
    end

    assert_hold_stable_R9_o0: assert property (@(posedge clk) disable iff (!rst_n)
        o0_valid && !o0_ready |=> o0_valid && $stable(o0_data));
    assert_hold_stable_R9_o1: assert property (@(posedge clk) disable iff (!rst_n)
        o1_valid && !o1_ready |=> o1_valid && $stable(o1_data));

    assert_route_R2_o0: assert property (@(posedge clk) disable iff (!rst_n)
        o0_valid |-> (o0_data[SEL_BIT] ? (hv[1] && !hd[1][SEL_BIT])
                                        : (hv[0] && !hd[0][SEL_BIT])));
    assert_route_R2_o1: assert property (@(posedge clk) disable iff (!rst_n)
        o1_valid |-> (o1_data[SEL_BIT] ? (hv[1] && hd[1][SEL_BIT])
                                        : (hv[0] && hd[0][SEL_BIT])));

    assert_no_drop_R8_i0: assert property (@(posedge clk) disable iff (!rst_n)
        hv[0] && !pop[0] |=> hv[0] && $stable(hd[0]));
    assert_no_drop_R8_i1: assert property (@(posedge clk) disable iff (!rst_n)
        hv[1] && !pop[1] |=> hv[1] && $stable(hd[1]));

    assert_round_robin_R10_o0: assert property (@(posedge clk) disable iff (!rst_n)
        o0_valid && o0_ready && req[0][0] && req[0][1]
        |=> !(req[0][0] && req[0][1]) || (o0_data[SEL_BIT] != $past(o0_data[SEL_BIT])));
    assert_round_robin_R10_o1: assert property (@(posedge clk) disable iff (!rst_n)
        o1_valid && o1_ready && req[1][0] && req[1][1]
        |=> !(req[1][0] && req[1][1]) || (o1_data[SEL_BIT] != $past(o1_data[SEL_BIT])));

endmodule

// File: rtl/omega_plane.sv
// Module omega_plane
// One direction of the network: log2(N) ranks of N/2 switches.
// REVERSE=0 builds the request plane: each rank is preceded by a shuffle and
// rank g steers on module bit (MSB - g). REVERSE=1 builds the mirror reply
// plane: ranks are fed straight, followed by an inverse shuffle, and rank g
// steers on module bit (MSB - (S-1-g)), so the recorded path is read from
// its right-hand end.
// Assumes: N is a power of two; the module field is the top S bits of a message.
module omega_plane
    import omega_pkg::*;
#(
    parameter int N       = 8,
    parameter int MSG_W   = 52,
    parameter bit REVERSE = 1'b0,
    localparam int S      = $clog2(N)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              in_valid,
    input  logic [N-1:0][MSG_W-1:0]   in_data,
    output logic [N-1:0]              in_ready,
    output logic [N-1:0]              out_valid,
    output logic [N-1:0][MSG_W-1:0]   out_data,
    input  logic [N-1:0]              out_ready
);

    // Links between ranks (index 0 = plane input, S = plane output).
    logic             lnk_v [S+1][N];
    logic [MSG_W-1:0] lnk_d [S+1][N];
    logic             lnk_r [S+1][N];
    // Switch-side positions of each rank.
    logic             si_v [S][N];
    logic [MSG_W-1:0] si_d [S][N];
    logic             si_r [S][N];
    logic             so_v [S][N];
    logic [MSG_W-1:0] so_d [S][N];
    logic             so_r [S][N];

    for (genvar j = 0; j < N; j++) begin : g_edge
        assign lnk_v[0][j] = in_valid[j];
        assign lnk_d[0][j] = in_data[j];
        assign in_ready[j] = lnk_r[0][j];
        assign out_valid[j] = lnk_v[S][j];
        assign out_data[j]  = lnk_d[S][j];
        assign lnk_r[S][j]  = out_ready[j];
    end

    for (genvar g = 0; g < S; g++) begin : g_rank
        localparam int SEL = MSG_W - 1 - (REVERSE ? (S - 1 - g) : g);

        for (genvar j = 0; j < N; j++) begin : g_wire
            if (!REVERSE) begin : g_fwd
                localparam int PJ = shuffle_idx(j, S);
                assign si_v[g][PJ]    = lnk_v[g][j];
                assign si_d[g][PJ]    = lnk_d[g][j];
                assign lnk_r[g][j]    = si_r[g][PJ];
                assign lnk_v[g+1][j]  = so_v[g][j];
                assign lnk_d[g+1][j]  = so_d[g][j];
                assign so_r[g][j]     = lnk_r[g+1][j];
            end else begin : g_rev
                localparam int QJ = unshuffle_idx(j, S);
                assign si_v[g][j]     = lnk_v[g][j];
                assign si_d[g][j]     = lnk_d[g][j];
                assign lnk_r[g][j]    = si_r[g][j];
                assign lnk_v[g+1][QJ] = so_v[g][j];
                assign lnk_d[g+1][QJ] = so_d[g][j];
                assign so_r[g][j]     = lnk_r[g+1][QJ];
            end
        end

        for (genvar s = 0; s < N/2; s++) begin : g_sw
            omega_switch #(
                .MSG_W   (MSG_W),
                .SEL_BIT (SEL)
            ) sw_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .i0_valid (si_v[g][2*s]),
                .i0_data  (si_d[g][2*s]),
                .i0_ready (si_r[g][2*s]),
                .i1_valid (si_v[g][2*s+1]),
                .i1_data  (si_d[g][2*s+1]),
                .i1_ready (si_r[g][2*s+1]),
                .o0_valid (so_v[g][2*s]),
                .o0_data  (so_d[g][2*s]),
                .o0_ready (so_r[g][2*s]),
                .o1_valid (so_v[g][2*s+1]),
                .o1_data  (so_d[g][2*s+1]),
                .o1_ready (so_r[g][2*s+1])
            );
        end
    end

endmodule

// File: rtl/omega_net.sv
// Module omega_net
// Top of the omega interconnect: a request plane from processor ports to
// memory ports and an independent reply plane back. The two planes share no
// wires, so requests and replies never compete inside the block.
// Message layout: {module[MOD_W], address[ADDR_W], opcode[1], value[DATA_W]}.
// Assumes: N_PORTS is a power of two; memories echo the module field of a
// request unchanged into its reply.
module omega_net #(
    parameter int  N_PORTS = 8,
    parameter int  ADDR_W  = 16,
    parameter int  DATA_W  = 32,
    localparam int MOD_W   = $clog2(N_PORTS),
    localparam int MSG_W   = MOD_W + ADDR_W + 1 + DATA_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_PORTS-1:0]              cpu_req_valid,
    input  logic [N_PORTS-1:0][MSG_W-1:0]   cpu_req_msg,
    output logic [N_PORTS-1:0]              cpu_req_ready,
    output logic [N_PORTS-1:0]              mem_req_valid,
    output logic [N_PORTS-1:0][MSG_W-1:0]   mem_req_msg,
    input  logic [N_PORTS-1:0]              mem_req_ready,
    input  logic [N_PORTS-1:0]              mem_rsp_valid,
    input  logic [N_PORTS-1:0][MSG_W-1:0]   mem_rsp_msg,
    output logic [N_PORTS-1:0]              mem_rsp_ready,
    output logic [N_PORTS-1:0]              cpu_rsp_valid,
    output logic [N_PORTS-1:0][MSG_W-1:0]   cpu_rsp_msg,
    input  logic [N_PORTS-1:0]              cpu_rsp_ready
);

    // Request plane: processor side to memory side.
    omega_plane #(
        .N       (N_PORTS),
        .MSG_W   (MSG_W),
        .REVERSE (1'b0)
    ) fwd_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (cpu_req_valid),
        .in_data   (cpu_req_msg),
        .in_ready  (cpu_req_ready),
        .out_valid (mem_req_valid),
        .out_data  (mem_req_msg),
        .out_ready (mem_req_ready)
    );

    // Reply plane: memory side back to processor side.
    omega_plane #(
        .N       (N_PORTS),
        .MSG_W   (MSG_W),
        .REVERSE (1'b1)
    ) rev_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (mem_rsp_valid),
        .in_data   (mem_rsp_msg),
        .in_ready  (mem_rsp_ready),
        .out_valid (cpu_rsp_valid),
        .out_data  (cpu_rsp_msg),
        .out_ready (cpu_rsp_ready)
    );

endmodule

// File: tb/omega_net_tb.sv
// Bench for omega_net: directed corner cases followed by seeded random
// traffic, with the memories modelled as reply queues in the bench.
module omega_net_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int S  = 3;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int MW = S + AW + 1 + DW;
    localparam int QD = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]         cpu_req_valid = '0;
    logic [N-1:0][MW-1:0] cpu_req_msg = '0;
    logic [N-1:0]         cpu_req_ready;
    logic [N-1:0]         mem_req_valid;
    logic [N-1:0][MW-1:0] mem_req_msg;
    logic [N-1:0]         mem_req_ready = '0;
    logic [N-1:0]         mem_rsp_valid = '0;
    logic [N-1:0][MW-1:0] mem_rsp_msg = '0;
    logic [N-1:0]         mem_rsp_ready;
    logic [N-1:0]         cpu_rsp_valid;
    logic [N-1:0][MW-1:0] cpu_rsp_msg;
    logic [N-1:0]         cpu_rsp_ready = '0;

    omega_net #(.N_PORTS(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_msg(cpu_req_msg), .cpu_req_ready(cpu_req_ready),
        .mem_req_valid(mem_req_valid), .mem_req_msg(mem_req_msg), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_msg(mem_rsp_msg), .mem_rsp_ready(mem_rsp_ready),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_msg(cpu_rsp_msg), .cpu_rsp_ready(cpu_rsp_ready)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench-side state.
    bit          busy [N];
    logic [MW-1:0] pend [N];
    int          seq_ctr [N];
    int          exp_dst [2048];
    logic        exp_op  [2048];
    logic [DW-1:0] exp_val [2048];
    int          t_send [2048];
    int          lat_fw [2048];
    int          t_mrsp [2048];
    int          lat_rv [2048];
    logic [MW-1:0] rbuf [N*QD];
    int          rhead [N];
    int          rcnt  [N];
    int          last_m [N*N];
    int          last_c [N*N];
    int          sent = 0;
    int          done = 0;
    int          cyc  = 0;
    bit          gen_en = 1'b0;
    int          gen_left = 0;
    int          str_src = 0, str_dst = 0, str_left = 0;
    logic [N-1:0] mrdy_lo = '0;
    bit          all_ready = 1'b1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [S-1:0] f_mod(input logic [MW-1:0] m);
        return m[MW-1 -: S];
    endfunction
    function automatic logic [AW-1:0] f_addr(input logic [MW-1:0] m);
        return m[MW-S-1 -: AW];
    endfunction
    function automatic logic f_op(input logic [MW-1:0] m);
        return m[DW];
    endfunction
    function automatic logic [DW-1:0] f_val(input logic [MW-1:0] m);
        return m[DW-1:0];
    endfunction
    function automatic int id_of(input logic [AW-1:0] a);
        return int'(a[AW-1 -: S]) * 256 + int'(a[7:0]);
    endfunction
    // Memory model reply value: read returns a pattern, write returns the complement.
    function automatic logic [DW-1:0] rsp_val(input int dst, input logic op,
                                              input logic [AW-1:0] a, input logic [DW-1:0] v);
        return op ? ~v : {a, 13'd0, 3'(dst)};
    endfunction

    function automatic int new_msg(input int src, input int dst, input logic op, input logic [DW-1:0] v);
        logic [AW-1:0] a;
        int id;
        a = {3'(src), 13'(seq_ctr[src])};
        seq_ctr[src]++;
        id = id_of(a);
        exp_dst[id] = dst;
        exp_op[id]  = op;
        exp_val[id] = v;
        pend[src] = {3'(dst), a, op, v};
        busy[src] = 1'b1;
        return id;
    endfunction

    // One clock: drive at the falling edge, evaluate handshakes 1 time unit later.
    task automatic step();
        int unused;
        @(negedge clk);
        cyc++;
        for (int i = 0; i < N; i++) begin
            if (!busy[i]) begin
                if (gen_en && gen_left > 0 && $urandom_range(0, 1) == 1) begin
                    unused = new_msg(i, $urandom_range(0, N-1), 1'($urandom_range(0, 1)), $urandom);
                    gen_left--;
                end else if (str_left > 0 && i == str_src) begin
                    unused = new_msg(i, str_dst, 1'b1, $urandom);
                    str_left--;
                end
            end
            cpu_req_valid[i] = busy[i];
            cpu_req_msg[i]   = pend[i];
            cpu_rsp_ready[i] = all_ready || ($urandom_range(0, 9) < 7);
        end
        for (int p = 0; p < N; p++) begin
            mem_req_ready[p] = !mrdy_lo[p] && (rcnt[p] < QD - 4) &&
                               (all_ready || ($urandom_range(0, 9) < 7));
            mem_rsp_valid[p] = (rcnt[p] > 0);
            mem_rsp_msg[p]   = rbuf[p*QD + rhead[p]];
        end
        #1;
        for (int i = 0; i < N; i++) begin
            if (cpu_req_valid[i] && cpu_req_ready[i]) begin
                busy[i] = 1'b0;
                sent++;
                t_send[id_of(f_addr(pend[i]))] = cyc;
            end
        end
        for (int p = 0; p < N; p++) begin
            if (mem_rsp_valid[p] && mem_rsp_ready[p]) begin
                t_mrsp[id_of(f_addr(mem_rsp_msg[p]))] = cyc;
                rhead[p] = (rhead[p] + 1) % QD;
                rcnt[p]--;
            end
        end
        for (int p = 0; p < N; p++) begin
            if (mem_req_valid[p] && mem_req_ready[p]) begin
                logic [MW-1:0] m;
                logic [AW-1:0] a;
                int id, src, key;
                m = mem_req_msg[p];
                a = f_addr(m);
                id = id_of(a);
                src = int'(a[AW-1 -: S]);
                check(p == exp_dst[id], "R2 delivery port", 64'(p), 64'(exp_dst[id]));
                check(int'(f_mod(m)) == src, "R3 recorded path", 64'(f_mod(m)), 64'(src));
                check({f_op(m), f_val(m)} == {exp_op[id], exp_val[id]}, "R4 request fields",
                      64'({f_op(m), f_val(m)}), 64'({exp_op[id], exp_val[id]}));
                key = src * N + p;
                check(int'(a[12:0]) > last_m[key], "R11 request order", 64'(a[12:0]), 64'(last_m[key]));
                last_m[key] = int'(a[12:0]);
                lat_fw[id] = cyc - t_send[id];
                rbuf[p*QD + (rhead[p] + rcnt[p]) % QD] =
                    {f_mod(m), a, f_op(m), rsp_val(p, f_op(m), a, f_val(m))};
                rcnt[p]++;
            end
        end
        for (int c = 0; c < N; c++) begin
            if (cpu_rsp_valid[c] && cpu_rsp_ready[c]) begin
                logic [MW-1:0] m;
                logic [AW-1:0] a;
                int id, src, key;
                logic [DW-1:0] ev;
                m = cpu_rsp_msg[c];
                a = f_addr(m);
                id = id_of(a);
                src = int'(a[AW-1 -: S]);
                ev = rsp_val(exp_dst[id], exp_op[id], a, exp_val[id]);
                check(c == src, "R5 reply port", 64'(c), 64'(src));
                check(int'(f_mod(m)) == exp_dst[id], "R5 restored module", 64'(f_mod(m)), 64'(exp_dst[id]));
                check(f_val(m) == ev && f_op(m) == exp_op[id], "R4 reply fields", 64'(f_val(m)), 64'(ev));
                key = src * N + exp_dst[id];
                check(int'(a[12:0]) > last_c[key], "R11 reply order", 64'(a[12:0]), 64'(last_c[key]));
                last_c[key] = int'(a[12:0]);
                lat_rv[id] = cyc - t_mrsp[id];
                done++;
            end
        end
    endtask

    function automatic bit any_busy();
        for (int i = 0; i < N; i++) if (busy[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic drain();
        int guard = 0;
        while ((done < sent || any_busy() || str_left > 0 || gen_left > 0) && guard < 20000) begin
            step();
            guard++;
        end
        check(guard < 20000, "R8 drain completes", 64'(done), 64'(sent));
        repeat (2) step();
    endtask

    // Watchdog: a hung run ends as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int ida, idb;
        bit win_a1, win_a2;
        logic [MW-1:0] snap;
        process::self().srandom(32'd5150);
        for (int k = 0; k < N*N; k++) begin
            last_m[k] = -1;
            last_c[k] = -1;
        end
        for (int i = 0; i < N; i++) begin
            busy[i] = 1'b0; seq_ctr[i] = 0; rhead[i] = 0; rcnt[i] = 0; pend[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle state after reset.
        step();
        check(mem_req_valid == '0, "R1 request outputs idle", 64'(mem_req_valid), 64'(0));
        check(cpu_rsp_valid == '0, "R1 reply outputs idle", 64'(cpu_rsp_valid), 64'(0));
        check(cpu_req_ready == '1, "R1 request inputs ready", 64'(cpu_req_ready), 64'(8'hff));
        check(mem_rsp_ready == '1, "R1 reply inputs ready", 64'(mem_rsp_ready), 64'(8'hff));

        // R6/R7: two disjoint paths in parallel (3 -> 6 and 1 -> 1).
        all_ready = 1'b1;
        ida = new_msg(3, 6, 1'b0, 32'h0);
        idb = new_msg(1, 1, 1'b1, 32'hCAFE_0001);
        drain();
        check(lat_fw[ida] == S, "R6 request latency", 64'(lat_fw[ida]), 64'(S));
        check(lat_fw[idb] == S, "R7 parallel delivery", 64'(lat_fw[idb]), 64'(S));
        check(lat_rv[ida] == S, "R6 reply latency", 64'(lat_rv[ida]), 64'(S));
        check(lat_rv[idb] == S, "R7 parallel replies", 64'(lat_rv[idb]), 64'(S));

        // R8/R10: processors 0 and 4 share a first-rank switch and both target memory 0.
        ida = new_msg(0, 0, 1'b1, 32'h1111_0000);
        idb = new_msg(4, 0, 1'b1, 32'h4444_0000);
        drain();
        check((lat_fw[ida] == S && lat_fw[idb] == S+1) || (lat_fw[ida] == S+1 && lat_fw[idb] == S),
              "R8 one waits one cycle", 64'({lat_fw[ida][15:0], lat_fw[idb][15:0]}), 64'(32'h0003_0004));
        win_a1 = (lat_fw[ida] == S);
        ida = new_msg(0, 0, 1'b0, 32'h0);
        idb = new_msg(4, 0, 1'b0, 32'h0);
        drain();
        check((lat_fw[ida] == S && lat_fw[idb] == S+1) || (lat_fw[ida] == S+1 && lat_fw[idb] == S),
              "R8 second contest", 64'({lat_fw[ida][15:0], lat_fw[idb][15:0]}), 64'(32'h0003_0004));
        win_a2 = (lat_fw[ida] == S);
        check(win_a1 != win_a2, "R10 grant alternates", 64'(win_a2), 64'(!win_a1));

        // R9: memory 0 stalls while processor 0 streams to it.
        mrdy_lo = 8'h01;
        str_src = 0; str_dst = 0; str_left = 6;
        repeat (12) step();
        check(cpu_req_ready[0] == 1'b0, "R9 input pushes back", 64'(cpu_req_ready[0]), 64'(0));
        check(mem_req_valid[0] == 1'b1, "R9 output held valid", 64'(mem_req_valid[0]), 64'(1));
        snap = mem_req_msg[0];
        repeat (5) step();
        check(mem_req_msg[0] == snap, "R9 output stable", 64'(mem_req_msg[0]), 64'(snap));
        check(mem_req_valid[0] == 1'b1, "R9 still valid", 64'(mem_req_valid[0]), 64'(1));
        mrdy_lo = '0;
        drain();

        // Random traffic with random readies.
        all_ready = 1'b0;
        gen_en = 1'b1;
        gen_left = 400;
        drain();
        gen_en = 1'b0;
        check(done == sent, "R8 nothing lost", 64'(done), 64'(sent));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule